// File: doc/BRIEF.md
# Dual-Issue Decode Hazard Stall Unit

This block decides, every cycle, whether the decode stage of a two-wide in-order pipeline must hold its instructions. Each of the two decode slots can read up to two source operands, A and B. Each source is checked against the destination of the instruction sitting in each of two later execute stages. A source and a destination can each be short, meaning one 32-bit register, or long, meaning a 64-bit even/odd register pair. The match logic therefore also catches overlap between registers of different widths.

A match is not a stall on its own. When an operand depends on an in-flight result, the result is normally forwarded. The decode stage is held only when forwarding is impossible: the producer has forwarding disabled, the producer needs two cycles to form its result, or the consumer operand and the producer result differ in width. The stall output is purely combinational from the current stage contents. Dependencies between the two decode slots are resolved elsewhere.

Top module: `hz_stall_unit`

## Requirements
- R1: With no valid decode slot reading a register that a valid in-flight instruction writes, `stall_o` is 0. This includes the all-zero input state.
- R2: A source whose id equals a producer's destination is dependent on it. When both are short, forwarding is enabled and the producer is single-cycle, `stall_o` stays 0.
- R3: A long source with id S also covers register S with bit 0 forced to 1. A short producer writing that odd register is a dependency. Because the widths differ, it stalls.
- R4: A long producer with destination D also writes D with bit 0 forced to 1. A short source reading that odd register is a dependency. Because the widths differ, it stalls.
- R5: A dependency where the consumer operand's long flag differs from the producer's long flag stalls. A long source and a long producer on the same pair do not stall for width.
- R6: A dependency on a producer with its two-cycle flag set stalls.
- R7: A dependency on a producer with forward-enable low stalls.
- R8: A dependency needs all four of the following, and a missing one never causes a stall: the consumer slot is valid, the operand's read enable is set, the producer is valid, and the producer's write enable is set.
- R9: Each decode slot is checked against each execute stage. A stall term from any slot, stage or operand raises `stall_o`.
- R10: Operand B follows exactly the same rules as operand A, using its own id, read enable and long flag.
- R11: `stall_o` follows the inputs in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_valid_i | input | NUM_SLOTS | Decode slot holds a valid instruction |
| dec_src_a_i | input | NUM_SLOTS x 4 | Operand A register id per slot |
| dec_src_b_i | input | NUM_SLOTS x 4 | Operand B register id per slot |
| dec_rd_a_i | input | NUM_SLOTS | Operand A is read |
| dec_rd_b_i | input | NUM_SLOTS | Operand B is read |
| dec_long_a_i | input | NUM_SLOTS | Operand A is a register pair |
| dec_long_b_i | input | NUM_SLOTS | Operand B is a register pair |
| ex_valid_i | input | NUM_STAGES | Execute stage holds a valid instruction |
| ex_dst_i | input | NUM_STAGES x 4 | Destination register id per stage |
| ex_wr_i | input | NUM_STAGES | Destination is written |
| ex_long_i | input | NUM_STAGES | Destination is a register pair |
| ex_fwd_en_i | input | NUM_STAGES | Result can be forwarded |
| ex_two_cyc_i | input | NUM_STAGES | Producer has two-cycle latency |
| stall_o | output | 1 | Hold the decode stage |

## Verification
The bench builds the block with its default parameters: two decode slots, two execute stages and 4-bit register ids. This covers the full 16-entry register file, so every even/odd pair and both neighbours of each pair boundary can be driven. It sweeps short and long sources against short and long destinations on adjacent ids (2 and 3), crossing the pair boundary in both directions. It then isolates each stall cause and each gating enable on one slot, stage and operand at a time. Finally, random traffic with ids drawn from a narrow range exercises coincident matches across all slots and stages.

// File: rtl/hz_pkg.sv
package hz_pkg;

  parameter int unsigned HZ_ID_W = 4;

  typedef logic [HZ_ID_W-1:0] hz_reg_id_t;

  // one consumer operand in decode
  typedef struct packed {
    logic       rd_en;
    logic       long_op;
    hz_reg_id_t id;
  } hz_src_t;

  // one producer in an execute stage
  typedef struct packed {
    logic       valid;
    logic       wr_en;
    logic       long_op;
    logic       fwd_en;
    logic       two_cyc;
    hz_reg_id_t dst;
  } hz_prod_t;

  // odd half of an even/odd register pair: force bit 0 high
  function automatic hz_reg_id_t hz_pair_hi(input hz_reg_id_t id);
    hz_reg_id_t r;
    r    = id;
    r[0] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/hz_reg_match.sv
module hz_reg_match
  import hz_pkg::*;
(
  input  hz_src_t  src,
  input  hz_prod_t prod,
  output logic     match_o
);

  logic exact_hit;
  logic src_hi_hit;
  logic dst_hi_hit;

  always_comb begin
    exact_hit  = (src.id == prod.dst);
    src_hi_hit = src.long_op  && (hz_pair_hi(src.id) == prod.dst);
    dst_hi_hit = prod.long_op && (src.id == hz_pair_hi(prod.dst));
    match_o    = exact_hit | src_hi_hit | dst_hi_hit;
  end

endmodule

// File: rtl/hz_operand_hazard.sv
module hz_operand_hazard
  import hz_pkg::*;
(
  input  logic     slot_valid,
  input  hz_src_t  src,
  input  hz_prod_t prod,
  output logic     stall_term_o
);

  logic reg_hit;
  logic dep;
  logic no_fwd;

  hz_reg_match i_match (
    .src     (src),
    .prod    (prod),
    .match_o (reg_hit)
  );

  always_comb begin
    dep          = reg_hit && src.rd_en && prod.wr_en && slot_valid && prod.valid;
    no_fwd       = !prod.fwd_en || prod.two_cyc || (src.long_op != prod.long_op);
    stall_term_o = dep && no_fwd;
  end

  always_comb begin
    if (!slot_valid || !prod.valid || !src.rd_en || !prod.wr_en)
      assert_gated_no_stall_R8: assert (!stall_term_o)
        else $error("gated operand produced a stall term");
    if (dep && prod.two_cyc)
      assert_two_cyc_stall_R6: assert (stall_term_o)
        else $error("two-cycle producer did not stall");
    if (dep && !prod.fwd_en)
      assert_no_fwd_stall_R7: assert (stall_term_o)
        else $error("unforwardable producer did not stall");
    if (dep && (src.long_op != prod.long_op))
      assert_width_stall_R5: assert (stall_term_o)
        else $error("width mismatch did not stall");
    if (slot_valid && prod.valid && src.rd_en && prod.wr_en && (src.id == prod.dst))
      assert_exact_dep_R2: assert (dep)
        else $error("exact id match not seen as dependency");
  end

endmodule

// File: rtl/hz_stall_unit.sv
module hz_stall_unit
  import hz_pkg::*;
#(
  parameter int unsigned NUM_SLOTS  = 2,
  parameter int unsigned NUM_STAGES = 2
) (
  input  logic [NUM_SLOTS-1:0]               dec_valid_i,
  input  logic [NUM_SLOTS-1:0][HZ_ID_W-1:0]  dec_src_a_i,
  input  logic [NUM_SLOTS-1:0][HZ_ID_W-1:0]  dec_src_b_i,
  input  logic [NUM_SLOTS-1:0]               dec_rd_a_i,
  input  logic [NUM_SLOTS-1:0]               dec_rd_b_i,
  input  logic [NUM_SLOTS-1:0]               dec_long_a_i,
  input  logic [NUM_SLOTS-1:0]               dec_long_b_i,
  input  logic [NUM_STAGES-1:0]              ex_valid_i,
  input  logic [NUM_STAGES-1:0][HZ_ID_W-1:0] ex_dst_i,
  input  logic [NUM_STAGES-1:0]              ex_wr_i,
  input  logic [NUM_STAGES-1:0]              ex_long_i,
  input  logic [NUM_STAGES-1:0]              ex_fwd_en_i,
  input  logic [NUM_STAGES-1:0]              ex_two_cyc_i,
  output logic                               stall_o
);

  localparam int unsigned NUM_OPS   = 2;
  localparam int unsigned NUM_TERMS = NUM_SLOTS * NUM_STAGES * NUM_OPS;

  hz_prod_t [NUM_STAGES-1:0] prod;
  logic     [NUM_TERMS-1:0]  terms;

  for (genvar x = 0; x < NUM_STAGES; x++) begin : g_prod
    assign prod[x] = '{valid:   ex_valid_i[x],
                       wr_en:   ex_wr_i[x],
                       long_op: ex_long_i[x],
                       fwd_en:  ex_fwd_en_i[x],
                       two_cyc: ex_two_cyc_i[x],
                       dst:     ex_dst_i[x]};
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    hz_src_t [NUM_OPS-1:0] srcs;
    assign srcs[0] = '{rd_en: dec_rd_a_i[s], long_op: dec_long_a_i[s], id: dec_src_a_i[s]};
    assign srcs[1] = '{rd_en: dec_rd_b_i[s], long_op: dec_long_b_i[s], id: dec_src_b_i[s]};
    for (genvar x = 0; x < NUM_STAGES; x++) begin : g_stage
      for (genvar o = 0; o < NUM_OPS; o++) begin : g_op
        hz_operand_hazard i_op (
          .slot_valid   (dec_valid_i[s]),
          .src          (srcs[o]),
          .prod         (prod[x]),
          .stall_term_o (terms[(s*NUM_STAGES + x)*NUM_OPS + o])
        );
      end
    end
  end

  assign stall_o = |terms;

  always_comb begin
    if (ex_valid_i == '0)
      assert_idle_stages_R8: assert (!stall_o)
        else $error("stall with no valid producer");
    if (dec_valid_i == '0)
      assert_idle_slots_R1: assert (!stall_o)
        else $error("stall with no valid consumer");
    if ((ex_wr_i & ex_valid_i) == '0)
      assert_no_writer_R1: assert (!stall_o)
        else $error("stall with no writing producer");
  end

endmodule

// File: tb/test_hz_stall_unit.sv
module test_hz_stall_unit;
  localparam int NS = 2;
  localparam int NX = 2;
  localparam int W  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  // behavioural stimulus state
  int  s_id  [NS][2];
  bit  s_rd  [NS][2];
  bit  s_lg  [NS][2];
  bit  s_v   [NS];
  int  p_dst [NX];
  bit  p_v [NX], p_wr [NX], p_lg [NX], p_fwd [NX], p_two [NX];

  logic [NS-1:0]        dv, rda, rdb, lga, lgb;
  logic [NS-1:0][W-1:0] sa, sb;
  logic [NX-1:0]        xv, xw, xl, xf, xt;
  logic [NX-1:0][W-1:0] xd;
  logic                 stall;

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      dv[i] = s_v[i];
      sa[i] = W'(s_id[i][0]);
      sb[i] = W'(s_id[i][1]);
      rda[i] = s_rd[i][0]; rdb[i] = s_rd[i][1];
      lga[i] = s_lg[i][0]; lgb[i] = s_lg[i][1];
    end
    for (int j = 0; j < NX; j++) begin
      xv[j] = p_v[j]; xw[j] = p_wr[j]; xl[j] = p_lg[j];
      xf[j] = p_fwd[j]; xt[j] = p_two[j]; xd[j] = W'(p_dst[j]);
    end
  end

  hz_stall_unit #(.NUM_SLOTS(NS), .NUM_STAGES(NX)) i_hz_stall_unit (
    .dec_valid_i(dv), .dec_src_a_i(sa), .dec_src_b_i(sb),
    .dec_rd_a_i(rda), .dec_rd_b_i(rdb), .dec_long_a_i(lga), .dec_long_b_i(lgb),
    .ex_valid_i(xv), .ex_dst_i(xd), .ex_wr_i(xw), .ex_long_i(xl),
    .ex_fwd_en_i(xf), .ex_two_cyc_i(xt), .stall_o(stall)
  );

  function automatic int odd_of(int r);
    return r - (r % 2) + 1;
  endfunction

  function automatic bit model_stall();
    for (int i = 0; i < NS; i++)
      for (int o = 0; o < 2; o++)
        for (int j = 0; j < NX; j++) begin
          bit hit;
          if (!s_v[i] || !s_rd[i][o] || !p_v[j] || !p_wr[j]) continue;
          hit = (s_id[i][o] == p_dst[j]) ||
                (s_lg[i][o] && odd_of(s_id[i][o]) == p_dst[j]) ||
                (p_lg[j] && s_id[i][o] == odd_of(p_dst[j]));
          if (hit && (!p_fwd[j] || p_two[j] || (s_lg[i][o] != p_lg[j]))) return 1'b1;
        end
    return 1'b0;
  endfunction

  task automatic clear_all();
    for (int i = 0; i < NS; i++) begin
      s_v[i] = 0;
      for (int o = 0; o < 2; o++) begin s_id[i][o] = 0; s_rd[i][o] = 0; s_lg[i][o] = 0; end
    end
    for (int j = 0; j < NX; j++) begin
      p_v[j] = 0; p_wr[j] = 0; p_lg[j] = 0; p_fwd[j] = 0; p_two[j] = 0; p_dst[j] = 0;
    end
  endtask

  task automatic set_src(int i, int o, int id, bit lg);
    s_v[i] = 1; s_id[i][o] = id; s_rd[i][o] = 1; s_lg[i][o] = lg;
  endtask

  task automatic set_prod(int j, int d, bit lg, bit fwd, bit two);
    p_v[j] = 1; p_wr[j] = 1; p_dst[j] = d; p_lg[j] = lg; p_fwd[j] = fwd; p_two[j] = two;
  endtask

  // compare at the falling edge; the next drive follows the rising edge
  task automatic check(string tag, bit exp_hand, bit use_hand);
    bit exp;
    @(negedge clk);
    exp = use_hand ? exp_hand : model_stall();
    tests++;
    if (stall !== exp) begin
      fails++;
      $display("FAIL %s: stall_o actual %0b expected %0b", tag, stall, exp);
    end
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    clear_all();
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    check("R1 idle", 1'b0, 1);

    // R2 exact short match, forwardable
    clear_all(); set_src(0, 0, 5, 0); set_prod(0, 5, 0, 1, 0);
    check("R2 exact fwd", 1'b0, 1);
    // R7 forward disabled
    p_fwd[0] = 0; check("R7 no fwd", 1'b1, 1);
    // R6 two-cycle producer
    p_fwd[0] = 1; p_two[0] = 1; check("R6 two cycle", 1'b1, 1);
    // R11 same-cycle release
    p_two[0] = 0; check("R11 release", 1'b0, 1);
    // R8 each gate removed
    p_fwd[0] = 0;
    s_rd[0][0] = 0; check("R8 no read", 1'b0, 1); s_rd[0][0] = 1;
    p_wr[0] = 0;    check("R8 no write", 1'b0, 1); p_wr[0] = 1;
    p_v[0] = 0;     check("R8 producer invalid", 1'b0, 1); p_v[0] = 1;
    s_v[0] = 0;     check("R8 slot invalid", 1'b0, 1); s_v[0] = 1;
    // R1 different register
    p_dst[0] = 6; check("R1 no match", 1'b0, 1);

    // R3/R4/R5 adjacent ids 2 and 3, all width combinations
    for (int s = 2; s <= 3; s++)
      for (int d = 2; d <= 3; d++)
        for (int cl = 0; cl < 2; cl++)
          for (int pl = 0; pl < 2; pl++) begin
            clear_all(); set_src(0, 0, s, cl); set_prod(0, d, pl, 1, 0);
            check(cl ? (pl ? "R5 long-long" : "R3 long src") :
                       (pl ? "R4 long dst" : "R2 short-short"), 1'b0, 0);
          end
    clear_all(); set_src(0, 0, 4, 1); set_prod(0, 5, 0, 1, 0); check("R3 src pair hi", 1'b1, 1);
    clear_all(); set_src(0, 0, 9, 0); set_prod(0, 8, 1, 1, 0); check("R4 dst pair hi", 1'b1, 1);
    clear_all(); set_src(0, 0, 8, 1); set_prod(0, 8, 1, 1, 0); check("R5 long match fwd", 1'b0, 1);
    clear_all(); set_src(0, 0, 8, 1); set_prod(0, 7, 1, 1, 0); check("R3 no cross pair", 1'b0, 1);

    // R10 operand B, R9 slot 1 / stage 1
    clear_all(); set_src(0, 1, 12, 0); set_prod(0, 12, 0, 0, 0); check("R10 operand B", 1'b1, 1);
    s_rd[0][1] = 0; check("R10 B read gate", 1'b0, 1);
    clear_all(); set_src(1, 0, 3, 0); set_prod(1, 3, 0, 1, 1); check("R9 slot1 stage1", 1'b1, 1);
    clear_all(); set_src(1, 1, 14, 1); set_prod(0, 15, 0, 1, 0); check("R9 slot1 B stage0", 1'b1, 1);

    // R9 random traffic with narrow ids
    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < NS; i++) begin
        s_v[i] = 1'($urandom);
        for (int o = 0; o < 2; o++) begin
          s_id[i][o] = int'($urandom_range(0, 5));
          s_rd[i][o] = 1'($urandom); s_lg[i][o] = 1'($urandom);
        end
      end
      for (int j = 0; j < NX; j++) begin
        p_v[j] = 1'($urandom); p_wr[j] = 1'($urandom); p_lg[j] = 1'($urandom);
        p_fwd[j] = ($urandom_range(0, 3) != 0); p_two[j] = ($urandom_range(0, 3) == 0);
        p_dst[j] = int'($urandom_range(0, 5));
      end
      check("R9 random", 1'b0, 0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule